// File: doc/BRIEF.md
# PWM Clock Enable Generator

This block derives the timing enables for a multi-channel PWM peripheral from the master clock. A free-running binary counter produces a set of prescaled enables, one for each power of two from 1 to 1024. Each enable is a one-cycle pulse in the master clock domain, not a derived clock. Channel logic picks one of these enables to advance its own period counter.

Two independent linear dividers, A and B, sit on top of the prescaler. Each divider takes the tap named by its prescaler-select field and divides it further by an 8-bit factor. This gives channel clocks that are not powers of two. A factor of zero, the reset value, keeps that divider silent. One write port loads the factor and select fields of both dividers at once. A single power enable input stands in for master clock gating: when it is low, every divided output stops.

Top module: `pwm_clkgen`

## Requirements
- R1: Tap k of `tap_en` (bit index k, 1 ≤ k ≤ 10) pulses high for one cycle once every 2^k enabled cycles. After reset it first fires on the 2^k-th enabled cycle.
- R2: Bit 0 of `tap_en` (the undivided clock) is high at all times, including during reset and while `pwr_en` is low.
- R3: With factor D in 1..255 and select P in 0..10, a divider output pulses once every D·2^P cycles.
- R4: While `rst_n` is low, taps 1..10 and both divider outputs are low. After reset, all factor and select fields are zero, so both divider outputs stay low until a write.
- R5: While `pwr_en` is low, taps 1..10 and both divider outputs are low, and the prescaler does not advance.
- R6: A factor of 0 keeps that divider output low permanently.
- R7: Select values 11 to 15 are reserved: the divider output stays low.
- R8: A write restarts the divider from zero. With P = 0, the first pulse comes in the D-th cycle after the write edge and not before.
- R9: With D = 1, the divider output equals the selected tap in every cycle.
- R10: When `cfg_we` is high at a rising edge, all four fields load together. After that, A and B run independently at their own periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Power enable; low stops all divided outputs |
| cfg_we | input | 1 | Loads the four configuration fields |
| cfg_pre_a | input | 4 | Prescaler tap select for divider A |
| cfg_div_a | input | 8 | Division factor for divider A (0 = off) |
| cfg_pre_b | input | 4 | Prescaler tap select for divider B |
| cfg_div_b | input | 8 | Division factor for divider B (0 = off) |
| tap_en | output | 11 | Prescaled enables, bit k pulses every 2^k cycles |
| clka_en | output | 1 | Divider A enable pulse |
| clkb_en | output | 1 | Divider B enable pulse |

## Verification
The bench builds the block with its default parameters: eleven taps and an 8-bit factor. This reaches every tap period up to 1024 and the reserved select codes 11 to 15. Divider periods are kept within a few thousand cycles (up to 2^10·2), so the top tap is exercised through a divider without running the full 1024·255 span. The exact cycle of the first pulse is checked after a write and after power is restored. These are the points where an off-by-one in the restart or hold logic would show.

// File: rtl/pwm_clkgen.sv
module pwm_clkgen #(
  parameter int NTAPS = 11,
  parameter int DIV_W = 8,
  localparam int PRE_W = $clog2(NTAPS),
  localparam int CNT_W = NTAPS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_en,
  input  logic             cfg_we,
  input  logic [PRE_W-1:0] cfg_pre_a,
  input  logic [DIV_W-1:0] cfg_div_a,
  input  logic [PRE_W-1:0] cfg_pre_b,
  input  logic [DIV_W-1:0] cfg_div_b,
  output logic [NTAPS-1:0] tap_en,
  output logic             clka_en,
  output logic             clkb_en
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt <= '0;
    else if (pwr_en) cnt <= cnt + 1'b1;

  assign tap_en[0] = 1'b1;

  for (genvar k = 1; k < NTAPS; k++) begin : g_tap
    assign tap_en[k] = pwr_en & (&cnt[k-1:0]);
  end

  logic [PRE_W-1:0] pre_r [2];
  logic [DIV_W-1:0] div_r [2];
  logic [DIV_W-1:0] dcnt  [2];
  logic [1:0]       hit;
  logic [PRE_W-1:0] new_pre [2];
  logic [DIV_W-1:0] new_div [2];

  assign new_pre[0] = cfg_pre_a;
  assign new_pre[1] = cfg_pre_b;
  assign new_div[0] = cfg_div_a;
  assign new_div[1] = cfg_div_b;

  for (genvar d = 0; d < 2; d++) begin : g_div
    logic sel, tick, on;

    always_comb begin
      sel = 1'b0;
      for (int k = 0; k < NTAPS; k++)
        if (pre_r[d] == PRE_W'(k)) sel = tap_en[k];
    end

    assign tick   = sel & pwr_en;
    assign on     = div_r[d] != '0;
    assign hit[d] = tick & on & (dcnt[d] == div_r[d] - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pre_r[d] <= '0;
        div_r[d] <= '0;
        dcnt[d]  <= '0;
      end else if (cfg_we) begin
        pre_r[d] <= new_pre[d];
        div_r[d] <= new_div[d];
        dcnt[d]  <= '0;
      end else if (tick && on) begin
        dcnt[d]  <= hit[d] ? '0 : dcnt[d] + 1'b1;
      end
  end

  assign clka_en = hit[0];
  assign clkb_en = hit[1];

endmodule

// File: rtl/pwm_clkgen_chk.sv
module pwm_clkgen_chk #(
  parameter int NTAPS = 11,
  parameter int DIV_W = 8,
  localparam int PRE_W = $clog2(NTAPS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_en,
  input logic             cfg_we,
  input logic [PRE_W-1:0] cfg_pre_a,
  input logic [DIV_W-1:0] cfg_div_a,
  input logic [PRE_W-1:0] cfg_pre_b,
  input logic [DIV_W-1:0] cfg_div_b,
  input logic [NTAPS-1:0] tap_en,
  input logic             clka_en,
  input logic             clkb_en
);

  logic [PRE_W-1:0] s_pre_a, s_pre_b;
  logic [DIV_W-1:0] s_div_a, s_div_b;
  logic             tsel_a, good_a;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_pre_a <= '0; s_div_a <= '0; s_pre_b <= '0; s_div_b <= '0;
    end else if (cfg_we) begin
      s_pre_a <= cfg_pre_a; s_div_a <= cfg_div_a;
      s_pre_b <= cfg_pre_b; s_div_b <= cfg_div_b;
    end

  always_comb begin
    tsel_a = 1'b0;
    good_a = 1'b0;
    for (int k = 0; k < NTAPS; k++)
      if (s_pre_a == PRE_W'(k)) begin
        tsel_a = tap_en[k];
        good_a = 1'b1;
      end
  end

  for (genvar k = 2; k < NTAPS; k++) begin : g_nest
    AST_TAP_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
      tap_en[k] |-> tap_en[k-1]); // R1
  end

  AST_UNDIVIDED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tap_en[0]); // R2

  AST_GATED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> (tap_en[NTAPS-1:1] == '0) && !clka_en && !clkb_en); // R5

  AST_ZERO_DIV_A: assert property (@(posedge clk) disable iff (!rst_n)
    (s_div_a == '0) |-> !clka_en); // R6

  AST_ZERO_DIV_B: assert property (@(posedge clk) disable iff (!rst_n)
    (s_div_b == '0) |-> !clkb_en); // R6

  AST_RESERVED_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    !good_a |-> !clka_en); // R7

  AST_DIV1_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_div_a == DIV_W'(1) && good_a) |-> clka_en == (tsel_a & pwr_en)); // R9

endmodule

bind pwm_clkgen pwm_clkgen_chk #(.NTAPS(NTAPS), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/pwm_clkgen_tb.sv
module pwm_clkgen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_en = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_pre_a = '0, cfg_pre_b = '0;
  logic [7:0]  cfg_div_a = '0, cfg_div_b = '0;
  logic [10:0] tap_en;
  logic        clka_en, clkb_en;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pwm_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .cfg_we(cfg_we),
    .cfg_pre_a(cfg_pre_a), .cfg_div_a(cfg_div_a),
    .cfg_pre_b(cfg_pre_b), .cfg_div_b(cfg_div_b),
    .tap_en(tap_en), .clka_en(clka_en), .clkb_en(clkb_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int w);
    if (w <= 10)      return tap_en[w];
    else if (w == 11) return clka_en;
    else              return clkb_en;
  endfunction

  task automatic do_reset(input logic pwr);
    rst_n = 1'b0;
    pwr_en = pwr;
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_cfg(input int pa, input int da, input int pb, input int db);
    @(negedge clk);
    cfg_pre_a = 4'(pa); cfg_div_a = 8'(da);
    cfg_pre_b = 4'(pb); cfg_div_b = 8'(db);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic period_of(input int w, output int per);
    int n = 0;
    while (!pick(w) && n < 6000) begin @(negedge clk); n++; end
    per = 0;
    do begin @(negedge clk); per++; end while (!pick(w) && per < 6000);
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    rst_n = 1'b0;
    #1;
    check(tap_en == 11'h001 && !clka_en && !clkb_en, "R4", int'(tap_en), 1);
    check(tap_en[0] == 1'b1, "R2", int'(tap_en[0]), 1);
    do_reset(1'b1);
    begin
      int seen = 0;
      repeat (60) begin @(negedge clk); if (clka_en || clkb_en) seen++; end
      check(seen == 0, "R4", seen, 0);
    end
  endtask

  task automatic t_taps();
    int p;
    do_reset(1'b1);
    for (int k = 1; k <= 10; k++) begin
      period_of(k, p);
      check(p == (1 << k), "R1", p, 1 << k);
    end
  endtask

  task automatic t_first_after_gate();
    int f1 = 0, f3 = 0;
    do_reset(1'b0);
    repeat (37) @(negedge clk);
    pwr_en = 1'b1;
    for (int i = 1; i <= 10; i++) begin
      #1;
      if (tap_en[1] && f1 == 0) f1 = i;
      if (tap_en[3] && f3 == 0) f3 = i;
      @(negedge clk);
    end
    check(f1 == 2, "R5", f1, 2);
    check(f3 == 8, "R1", f3, 8);
  endtask

  task automatic t_gate();
    int bad = 0;
    do_reset(1'b1);
    write_cfg(0, 1, 1, 1);
    pwr_en = 1'b0;
    repeat (100) begin
      #1;
      if (tap_en != 11'h001 || clka_en || clkb_en) bad++;
      if (!tap_en[0]) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R5", bad, 0);
    check(bad == 0, "R2", bad, 0);
    pwr_en = 1'b1;
  endtask

  task automatic t_periods();
    int p;
    do_reset(1'b1);
    write_cfg(3, 5, 0, 7);
    period_of(11, p); check(p == 40, "R3", p, 40);
    period_of(12, p); check(p == 7, "R3", p, 7);
    write_cfg(10, 2, 0, 0);
    period_of(11, p); check(p == 2048, "R3", p, 2048);
    write_cfg(1, 3, 2, 5);
    period_of(11, p); check(p == 6, "R10", p, 6);
    period_of(12, p); check(p == 20, "R10", p, 20);
  endtask

  task automatic t_restart();
    int bad = 0;
    do_reset(1'b1);
    write_cfg(0, 9, 0, 0);
    repeat (5) @(negedge clk);
    write_cfg(0, 6, 0, 0);
    for (int i = 1; i <= 6; i++) begin
      if (clka_en != (i == 6)) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R8", bad, 0);
  endtask

  task automatic t_div1();
    int bad = 0;
    do_reset(1'b1);
    write_cfg(2, 1, 0, 1);
    repeat (64) begin
      if (clka_en != tap_en[2]) bad++;
      if (clkb_en != 1'b1) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R9", bad, 0);
  endtask

  task automatic t_off();
    int seen = 0;
    do_reset(1'b1);
    write_cfg(0, 0, 0, 0);
    repeat (3000) begin @(negedge clk); if (clka_en || clkb_en) seen++; end
    check(seen == 0, "R6", seen, 0);
    seen = 0;
    for (int r = 11; r <= 15; r++) begin
      write_cfg(r, 1, r, 2);
      repeat (300) begin @(negedge clk); if (clka_en || clkb_en) seen++; end
    end
    check(seen == 0, "R7", seen, 0);
  endtask

  initial begin
    #(20 * 190000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_taps();
    t_first_after_gate();
    t_gate();
    t_periods();
    t_restart();
    t_div1();
    t_off();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule